// File: doc/BRIEF.md
# Multichannel Acquisition Sequencer

This block is the digital controller in front of an external analog-to-digital converter that serves several analog inputs through a multiplexer. A host asks for one reading at a time by presenting a channel number with a request strobe. The sequencer puts that channel on the multiplexer select lines. When the channel has changed, it waits a host-programmed number of cycles so the multiplexer output can settle. It then gives the sample-and-hold a short sample pulse and keeps it in hold for the rest of the operation. Next it raises start-of-convert to the converter for one cycle and waits for end-of-convert.

On completion the converter result and the channel it belongs to are latched, and a data-valid flag is raised. The host reads them through a port that is gated by a read enable. When the enable is low the port drives zeros, which stands in for three-state output buffers. A read clears the data-valid flag. If the converter never answers, a timeout returns the sequencer to idle and raises an error flag. Requests that arrive while an operation is in progress are dropped, and a busy flag tells the host when it may ask again.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, busy, err, dvalid, sh_sample and soc are 0 and mux_sel is 0.
- R2: When idle, a request (req_valid high at a clock edge) is accepted. From the next cycle busy is 1 and mux_sel equals the requested channel.
- R3: If the requested channel differs from the current mux_sel and settle_cycles (captured at acceptance) is nonzero, sh_sample stays low for exactly settle_cycles cycles after acceptance. Otherwise sh_sample rises in the cycle right after acceptance.
- R4: sh_sample stays high for exactly SAMPLE_CYC consecutive cycles. soc is high for exactly one cycle, the cycle in which sh_sample has just fallen.
- R5: From the end of the sample pulse until busy falls, sh_sample stays low (hold) and mux_sel does not change.
- R6: An eoc seen while waiting for the converter latches adc_data and the channel. In the next cycle dvalid is 1 and busy is 0.
- R7: A request made while busy is ignored. It does not change mux_sel or the channel or data of the operation in progress.
- R8: If eoc does not arrive within TIMEOUT_CYC cycles after the soc cycle, busy falls and err becomes 1 with no new data latched. err clears in the cycle after the next accepted request.
- R9: rd_data and rd_chan are all zeros while rd_en is low. While rd_en is high they show the latched result and channel, in the same cycle.
- R10: rd_en high at a clock edge clears dvalid for the next cycle. A capture at the same edge takes priority and leaves dvalid at 1.
- R11: eoc is ignored outside the wait-for-converter phase. It latches nothing and does not set dvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_chan | input | CHAN_W | Requested channel |
| settle_cycles | input | SETTLE_W | Settling wait after a channel change, in cycles |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Last operation timed out |
| mux_sel | output | CHAN_W | Analog multiplexer select |
| sh_sample | output | 1 | Sample-and-hold control, 1 = sample, 0 = hold |
| soc | output | 1 | Start-of-convert to converter |
| eoc | input | 1 | End-of-convert from converter |
| adc_data | input | DATA_W | Converter result |
| rd_en | input | 1 | Host read enable, gates the read port |
| rd_data | output | DATA_W | Gated result |
| rd_chan | output | CHAN_W | Gated channel of the result |
| dvalid | output | 1 | Unread result available |

## Verification
The assertions check the phase ordering on every cycle. They cover the one-cycle start pulse right after the sample pulse falls, sampling only while busy, and the select lines held steady during an operation. They also cover the gated read port reading zero when disabled, the read-clear of data-valid, and a counter-based bound on the time spent waiting for the converter. Some behaviour can only be shown by the bench's scenarios: the exact settle and sample durations, the captured data and channel values, requests dropped while busy, eoc pulses ignored outside the wait phase, and the error flag clearing on the next accepted request. The bench drives these against a behavioural converter model.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_START  = 3'd3,
        ST_WAIT   = 3'd4
    } acq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int CHAN_W      = 3,
    parameter int SETTLE_W    = 8,
    parameter int SAMPLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                eoc,
    output logic [CHAN_W-1:0]   mux_sel,
    output logic                sh_sample,
    output logic                soc,
    output logic                busy,
    output logic                err,
    output logic                capture
);

    localparam int SETTLE_MAX = (1 << SETTLE_W) - 1;
    localparam int CNT_MAX    = max3(SETTLE_MAX, SAMPLE_CYC, TIMEOUT_CYC);
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SMP_LOAD = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LOAD  = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        acq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CHAN_W-1:0] chan;
        logic              err;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  capture_d;

    always_comb begin
        ctrl_d    = ctrl_q;
        capture_d = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.chan = req_chan;
                    ctrl_d.err  = 1'b0;
                    if ((req_chan != ctrl_q.chan) && (settle_cycles != '0)) begin
                        ctrl_d.st  = ST_SETTLE;
                        ctrl_d.cnt = CNT_W'(settle_cycles) - CNT_W'(1);
                    end else begin
                        ctrl_d.st  = ST_SAMPLE;
                        ctrl_d.cnt = SMP_LOAD;
                    end
                end
            end
            ST_SETTLE: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st  = ST_SAMPLE;
                    ctrl_d.cnt = SMP_LOAD;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - CNT_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (ctrl_q.cnt == '0) begin
                    ctrl_d.st = ST_START;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - CNT_W'(1);
                end
            end
            ST_START: begin
                ctrl_d.st  = ST_WAIT;
                ctrl_d.cnt = TO_LOAD;
            end
            ST_WAIT: begin
                if (eoc) begin
                    capture_d = 1'b1;
                    ctrl_d.st = ST_IDLE;
                end else if (ctrl_q.cnt == '0) begin
                    ctrl_d.st  = ST_IDLE;
                    ctrl_d.err = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - CNT_W'(1);
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.cnt  <= '0;
            ctrl_q.chan <= '0;
            ctrl_q.err  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mux_sel   = ctrl_q.chan;
    assign sh_sample = (ctrl_q.st == ST_SAMPLE);
    assign soc       = (ctrl_q.st == ST_START);
    assign busy      = (ctrl_q.st != ST_IDLE);
    assign err       = ctrl_q.err;
    assign capture   = capture_d;

endmodule

// File: rtl/acq_result.sv
module acq_result #(
    parameter int CHAN_W = 3,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              rd_en,
    output logic [DATA_W-1:0] res_data,
    output logic [CHAN_W-1:0] res_chan,
    output logic              dvalid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHAN_W-1:0] chan;
        logic              vld;
    } res_s;

    res_s res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (capture) begin
            res_d.data = adc_data;
            res_d.chan = chan_in;
            res_d.vld  = 1'b1;
        end else if (rd_en) begin
            res_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q.data <= '0;
            res_q.chan <= '0;
            res_q.vld  <= 1'b0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_data = res_q.data;
    assign res_chan = res_q.chan;
    assign dvalid   = res_q.vld;

endmodule

// File: rtl/acq_out_gate.sv
module acq_out_gate #(
    parameter int WIDTH = 8
) (
    input  logic             oe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = oe & din[i];
    end

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
    parameter int CHAN_W      = 3,
    parameter int DATA_W      = 12,
    parameter int SETTLE_W    = 8,
    parameter int SAMPLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                busy,
    output logic                err,
    output logic [CHAN_W-1:0]   mux_sel,
    output logic                sh_sample,
    output logic                soc,
    input  logic                eoc,
    input  logic [DATA_W-1:0]   adc_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CHAN_W-1:0]   rd_chan,
    output logic                dvalid
);

    logic              capture;
    logic [DATA_W-1:0] res_data;
    logic [CHAN_W-1:0] res_chan;

    acq_ctrl #(
        .CHAN_W      (CHAN_W),
        .SETTLE_W    (SETTLE_W),
        .SAMPLE_CYC  (SAMPLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_chan      (req_chan),
        .settle_cycles (settle_cycles),
        .eoc           (eoc),
        .mux_sel       (mux_sel),
        .sh_sample     (sh_sample),
        .soc           (soc),
        .busy          (busy),
        .err           (err),
        .capture       (capture)
    );

    acq_result #(
        .CHAN_W (CHAN_W),
        .DATA_W (DATA_W)
    ) i_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .adc_data (adc_data),
        .chan_in  (mux_sel),
        .rd_en    (rd_en),
        .res_data (res_data),
        .res_chan (res_chan),
        .dvalid   (dvalid)
    );

    acq_out_gate #(.WIDTH(DATA_W)) i_gate_data (
        .oe   (rd_en),
        .din  (res_data),
        .dout (rd_data)
    );

    acq_out_gate #(.WIDTH(CHAN_W)) i_gate_chan (
        .oe   (rd_en),
        .din  (res_chan),
        .dout (rd_chan)
    );

endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
    parameter int CHAN_W      = 3,
    parameter int DATA_W      = 12,
    parameter int TIMEOUT_CYC = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CHAN_W-1:0] req_chan,
    input logic              busy,
    input logic              err,
    input logic [CHAN_W-1:0] mux_sel,
    input logic              sh_sample,
    input logic              soc,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [CHAN_W-1:0] rd_chan,
    input logic              dvalid
);

    localparam int WC_W = $clog2(TIMEOUT_CYC + 2);

    logic            in_wait_q;
    logic [WC_W-1:0] wait_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_wait_q  <= 1'b0;
            wait_cnt_q <= '0;
        end else if (soc) begin
            in_wait_q  <= 1'b1;
            wait_cnt_q <= '0;
        end else if (!busy) begin
            in_wait_q <= 1'b0;
        end else if (in_wait_q) begin
            wait_cnt_q <= wait_cnt_q + WC_W'(1);
        end
    end

    // R2: acceptance from idle
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && mux_sel == $past(req_chan)));

    // R4: start pulse directly follows the sample pulse
    a_r4_soc_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_sample) |-> soc);

    a_r4_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> !soc);

    a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sh_sample, soc}));

    // R5: sampling only inside an operation
    a_r5_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sh_sample |-> busy);

    // R7: select lines frozen while busy
    a_r7_busy_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mux_sel));

    // R6: new data appears as the operation ends
    a_r6_valid_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvalid) |-> !busy);

    // R8: error only when back in idle, bounded wait
    a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_q && busy) |-> (wait_cnt_q < WC_W'(TIMEOUT_CYC)));

    // R9: gated read port
    a_r9_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0 && rd_chan == '0));

    // R10: read clears valid unless a capture lands at the same edge
    a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && rd_en) |=> (!dvalid || $fell(busy)));

endmodule

bind acq_sequencer acq_sequencer_chk #(
    .CHAN_W      (CHAN_W),
    .DATA_W      (DATA_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .busy      (busy),
    .err       (err),
    .mux_sel   (mux_sel),
    .sh_sample (sh_sample),
    .soc       (soc),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_chan   (rd_chan),
    .dvalid    (dvalid)
);

// File: tb/test_acq_sequencer.sv
module test_acq_sequencer;

    localparam int CHAN_W      = 3;
    localparam int DATA_W      = 10;
    localparam int SETTLE_W    = 6;
    localparam int SAMPLE_CYC  = 2;
    localparam int TIMEOUT_CYC = 40;
    localparam int CONV_LAT    = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [CHAN_W-1:0]   req_chan = '0;
    logic [SETTLE_W-1:0] settle_cycles = '0;
    logic                busy, err, sh_sample, soc, dvalid;
    logic [CHAN_W-1:0]   mux_sel, rd_chan;
    logic                eoc;
    logic [DATA_W-1:0]   adc_data, rd_data;
    logic                rd_en = 1'b0;

    logic                stub_en = 1'b1;
    logic                stub_eoc = 1'b0;
    logic [DATA_W-1:0]   stub_data = '0;
    logic                spur_eoc = 1'b0;
    int                  conv_cnt = 0;
    logic [CHAN_W-1:0]   held_chan = '0;
    logic                hold_viol = 1'b0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    assign eoc      = stub_eoc | spur_eoc;
    assign adc_data = spur_eoc ? '1 : stub_data;

    acq_sequencer #(
        .CHAN_W      (CHAN_W),
        .DATA_W      (DATA_W),
        .SETTLE_W    (SETTLE_W),
        .SAMPLE_CYC  (SAMPLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_acq_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_chan      (req_chan),
        .settle_cycles (settle_cycles),
        .busy          (busy),
        .err           (err),
        .mux_sel       (mux_sel),
        .sh_sample     (sh_sample),
        .soc           (soc),
        .eoc           (eoc),
        .adc_data      (adc_data),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .rd_chan       (rd_chan),
        .dvalid        (dvalid)
    );

    function automatic logic [DATA_W-1:0] pattern(input logic [CHAN_W-1:0] c);
        return DATA_W'(c) * DATA_W'(37) + DATA_W'(101);
    endfunction

    // behavioural converter model
    always @(posedge clk) begin
        stub_eoc <= 1'b0;
        if (!rst_n) begin
            conv_cnt <= 0;
        end else if (soc && stub_en) begin
            conv_cnt  <= CONV_LAT;
            held_chan <= mux_sel;
        end else if (conv_cnt != 0) begin
            if (sh_sample || mux_sel != held_chan) hold_viol <= 1'b1;
            conv_cnt <= conv_cnt - 1;
            if (conv_cnt == 1) begin
                stub_eoc  <= 1'b1;
                stub_data <= pattern(held_chan);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic wait_idle(input int limit);
        int n = 0;
        while (busy && n < limit) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic accept(input logic [CHAN_W-1:0] c, input int s);
        @(negedge clk);
        req_valid     = 1'b1;
        req_chan      = c;
        settle_cycles = SETTLE_W'(s);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R2 busy", int'(busy), 1);
        check(mux_sel === c, "R2 mux_sel", int'(mux_sel), int'(c));
        check(err === 1'b0, "R8 err cleared on accept", int'(err), 0);
    endtask

    task automatic t_reset();
        check(busy === 1'b0 && err === 1'b0, "R1 busy/err", int'({busy, err}), 0);
        check(dvalid === 1'b0, "R1 dvalid", int'(dvalid), 0);
        check(sh_sample === 1'b0 && soc === 1'b0, "R1 sample/soc", int'({sh_sample, soc}), 0);
        check(mux_sel === '0, "R1 mux_sel", int'(mux_sel), 0);
    endtask

    task automatic read_result(input logic [CHAN_W-1:0] c);
        check(rd_data === '0 && rd_chan === '0, "R9 gated off", int'(rd_data), 0);
        rd_en = 1'b1;
        #1;
        check(rd_data === pattern(c), "R6 R9 data", int'(rd_data), int'(pattern(c)));
        check(rd_chan === c, "R6 R9 chan", int'(rd_chan), int'(c));
        @(negedge clk);
        rd_en = 1'b0;
        check(dvalid === 1'b0, "R10 read clears", int'(dvalid), 0);
    endtask

    task automatic t_conv(input logic [CHAN_W-1:0] c, input int s, input int exp_settle);
        int n = 0;
        int w = 0;
        hold_viol = 1'b0;
        accept(c, s);
        while (!sh_sample && n < 300) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_settle, "R3 settle cycles", n, exp_settle);
        while (sh_sample && w < 300) begin
            w++;
            @(negedge clk);
        end
        check(w == SAMPLE_CYC, "R4 sample width", w, SAMPLE_CYC);
        check(soc === 1'b1, "R4 soc after sample", int'(soc), 1);
        @(negedge clk);
        check(soc === 1'b0, "R4 soc one cycle", int'(soc), 0);
        wait_idle(200);
        check(busy === 1'b0 && dvalid === 1'b1, "R6 done", int'({busy, dvalid}), 1);
        check(hold_viol === 1'b0, "R5 hold through conversion", int'(hold_viol), 0);
        read_result(c);
    endtask

    task automatic t_reject();
        accept(3'd5, 3);
        for (int i = 0; i < 6; i++) begin
            req_valid = 1'b1;
            req_chan  = 3'd2;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(mux_sel === 3'd5, "R7 mux kept", int'(mux_sel), 5);
        wait_idle(200);
        check(dvalid === 1'b1, "R7 original completes", int'(dvalid), 1);
        read_result(3'd5);
        @(negedge clk);
        check(busy === 1'b0, "R7 no late start", int'(busy), 0);
    endtask

    task automatic t_timeout();
        int n = 0;
        stub_en = 1'b0;
        accept(3'd1, 2);
        while (!soc && n < 300) begin
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        n = 0;
        while (busy && n < 300) begin
            n++;
            @(negedge clk);
        end
        check(n == TIMEOUT_CYC, "R8 timeout length", n, TIMEOUT_CYC);
        check(err === 1'b1, "R8 err set", int'(err), 1);
        check(dvalid === 1'b0, "R8 no data", int'(dvalid), 0);
        stub_en = 1'b1;
        t_conv(3'd1, 2, 0);
        check(err === 1'b0, "R8 err stays clear", int'(err), 0);
    endtask

    task automatic t_spurious();
        @(negedge clk);
        spur_eoc = 1'b1;
        @(negedge clk);
        spur_eoc = 1'b0;
        check(dvalid === 1'b0, "R11 idle eoc ignored", int'(dvalid), 0);
        accept(3'd4, 6);
        @(negedge clk);
        spur_eoc = 1'b1;
        @(negedge clk);
        spur_eoc = 1'b0;
        check(dvalid === 1'b0, "R11 settle eoc ignored", int'(dvalid), 0);
        wait_idle(200);
        read_result(3'd4);
    endtask

    task automatic t_capture_priority();
        rd_en = 1'b1;
        accept(3'd2, 0);
        wait_idle(200);
        check(dvalid === 1'b1, "R10 capture wins", int'(dvalid), 1);
        check(rd_data === pattern(3'd2), "R10 data", int'(rd_data), int'(pattern(3'd2)));
        @(negedge clk);
        rd_en = 1'b0;
        check(dvalid === 1'b0, "R10 later read clears", int'(dvalid), 0);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_conv(3'd0, 5, 0);
        t_conv(3'd3, 4, 4);
        t_conv(3'd3, 4, 0);
        t_conv(3'd6, 0, 0);
        t_conv(3'd7, 1, 1);
        t_reject();
        t_timeout();
        t_spurious();
        t_capture_priority();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule